// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave Controller

This block is the bus-facing engine of a byte-wide serial EEPROM that sits on an open-drain two-wire bus. It watches the clock and data lines, sampled into a fast system clock domain. It recognises bus start and stop events and decodes a header byte. The header carries two device-select bits, the top five bits of a 13-bit word address, and the transfer direction. Writes are collected into a 32-byte page buffer. The buffer is committed to an external synchronous byte memory during a self-timed busy period that begins at the closing stop event.

Reads stream bytes out of the same memory for as long as the bus master keeps acknowledging. A read can start at the internal address counter (current-address read), or at an address loaded by a header-only write followed by a repeated start (random read). While the internal write runs, the block does not answer on the bus at all. A master can therefore poll for completion by sending headers until one is acknowledged.

Top module: `serial_eeprom_slave`

## Requirements
- R1: After reset the SDA pull-down is released and no memory write is issued.
- R2: A start event is SDA falling while SCL is high, and a stop event is SDA rising while SCL is high. A header is accepted only when its bit 7 equals the inverse of `dev_sel_i[1]` and its bit 6 equals `dev_sel_i[0]`. A rejected header gets no acknowledge, and the block then ignores the bus until the next start event.
- R3: Header bits 5 down to 1 are address bits 12 to 8, and header bit 0 is the direction (1 = read, 0 = write). On a write, the next byte supplies address bits 7 to 0. The block acknowledges each accepted byte by pulling SDA low for the ninth clock.
- R4: Successive data bytes of a write advance only the low five address bits. The upper eight bits stay fixed, so more than 32 bytes wrap inside the page and overwrite earlier bytes.
- R5: The internal write starts at the stop event that closes a write. For WR_CYCLES system clocks the block leaves SDA released and does not acknowledge headers. After that time, a new header is acknowledged again.
- R6: A stop event in the middle of a byte discards the partial byte. A write that delivered no complete data byte starts no internal write, so the next header is acknowledged at once.
- R7: Read data goes out MSB first, and SDA changes only while SCL is low. Another byte follows only when the master pulls SDA low on the ninth clock. On a master no-acknowledge the block releases SDA for the rest of the transfer.
- R8: A current-address read starts at the address of the last byte written, or at one past the last byte read.
- R9: During reads the address counter advances across all 13 bits and wraps from 8191 to 0.
- R10: A random read is a write header plus low address byte, then a repeated start with a read header. It returns data from the loaded address.
- R11: Each internal write issues exactly one memory write per distinct buffered byte. All of them fall within one page, and only during the busy period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, much faster than SCL |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_lo_o | output | 1 | Drives the data line low when 1 |
| dev_sel_i | input | 2 | Strap pins for the device-select compare |
| mem_addr_o | output | ADDR_W | Memory address (read or write) |
| mem_we_o | output | 1 | Memory write strobe |
| mem_wdata_o | output | 8 | Memory write data |
| mem_rdata_i | input | 8 | Memory read data, one cycle after the address |

## Verification
The assertions assume a well-behaved master. SCL and SDA never change in the same system clock. Each SCL phase lasts well beyond the synchroniser delay. A stop event is issued only while the block has released SDA, and the select straps stay static. Without these conditions, the rule that the pull-down changes only while SCL is low cannot hold. The bench master moves one line at a time, with eight system clocks between moves, and always leaves the ninth clock of a read to the block before it closes with a stop event.

// File: rtl/seep_pkg.sv
package seep_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_WORD,
    ST_WDATA,
    ST_RDATA
  } seep_state_e;

  localparam int unsigned BYTE_W = 8;
endpackage

// File: rtl/seep_line_sync.sv
module seep_line_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_q, sda_q;
  logic scl_p, sda_p, scl_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= '1;
      sda_q <= '1;
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_q <= {scl_q[STAGES-2:0], scl_i};
      sda_q <= {sda_q[STAGES-2:0], sda_i};
      scl_p <= scl_q[STAGES-1];
      sda_p <= sda_q[STAGES-1];
    end
  end

  assign scl_s      = scl_q[STAGES-1];
  assign sda_o      = sda_q[STAGES-1];
  assign scl_rise_o = scl_s & ~scl_p;
  assign scl_fall_o = ~scl_s & scl_p;
  assign start_o    = scl_s & scl_p & sda_p & ~sda_o;
  assign stop_o     = scl_s & scl_p & ~sda_p & sda_o;
endmodule

// File: rtl/seep_page_buf.sv
module seep_page_buf #(
  parameter int unsigned PAGE_W = 5
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     we_i,
  input  logic [PAGE_W-1:0]        widx_i,
  input  logic [7:0]               wdata_i,
  input  logic                     clr_i,
  input  logic [PAGE_W-1:0]        ridx_i,
  output logic [7:0]               rdata_o,
  output logic [(1<<PAGE_W)-1:0]   valid_o
);
  localparam int unsigned DEPTH = 1 << PAGE_W;

  logic [7:0]       data_q [DEPTH];
  logic [DEPTH-1:0] valid_q;

  always_ff @(posedge clk_i) begin
    if (we_i) data_q[widx_i] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    valid_q <= '0;
    else if (clr_i) valid_q <= '0;
    else if (we_i)  valid_q[widx_i] <= 1'b1;
  end

  assign rdata_o = data_q[ridx_i];
  assign valid_o = valid_q;
endmodule

// File: rtl/seep_wr_timer.sv
module seep_wr_timer #(
  parameter int unsigned WR_CYCLES = 256,
  parameter int unsigned PAGE_W    = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              go_i,
  output logic              busy_o,
  output logic              commit_o,
  output logic              done_o,
  output logic [PAGE_W-1:0] idx_o
);
  localparam int unsigned CNT_W = $clog2(WR_CYCLES);
  localparam logic [CNT_W-1:0] LAST  = CNT_W'(WR_CYCLES - 1);
  localparam logic [CNT_W-1:0] PAGES = CNT_W'(1 << PAGE_W);

  logic [CNT_W-1:0] cnt_q;
  logic             busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (!busy_q) begin
      if (go_i) begin
        busy_q <= 1'b1;
        cnt_q  <= '0;
      end
    end else if (cnt_q == LAST) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign busy_o   = busy_q;
  assign commit_o = busy_q && (cnt_q < PAGES);
  assign done_o   = busy_q && (cnt_q == LAST);
  assign idx_o    = cnt_q[PAGE_W-1:0];
endmodule

// File: rtl/serial_eeprom_slave.sv
module serial_eeprom_slave
  import seep_pkg::*;
#(
  parameter int unsigned ADDR_W      = 13,
  parameter int unsigned PAGE_W      = 5,
  parameter int unsigned WR_CYCLES   = 256,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_lo_o,
  input  logic [1:0]        dev_sel_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_we_o,
  output logic [7:0]        mem_wdata_o,
  input  logic [7:0]        mem_rdata_i
);
  localparam int unsigned HI_W = ADDR_W - BYTE_W;

  logic sda_s, scl_rise, scl_fall, start_ev, stop_ev;
  logic busy, tmr_commit, tmr_done;
  logic [PAGE_W-1:0] tmr_idx;
  logic [(1<<PAGE_W)-1:0] pb_valid;
  logic pb_we, pb_clr, hdr_match;

  seep_state_e       st_q;
  logic [3:0]        bit_q;
  logic [7:0]        sh_q, tx_q;
  logic              sda_lo_q, rd_q;
  logic [HI_W-1:0]   hi_q;
  logic [ADDR_W-1:0] ptr_q, waddr_q;

  seep_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .sda_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_ev), .stop_o(stop_ev)
  );

  seep_wr_timer #(.WR_CYCLES(WR_CYCLES), .PAGE_W(PAGE_W)) u_tmr (
    .clk_i, .rst_ni,
    .go_i(stop_ev & ~busy & (|pb_valid)),
    .busy_o(busy), .commit_o(tmr_commit), .done_o(tmr_done), .idx_o(tmr_idx)
  );

  assign pb_we  = ~busy & ~start_ev & ~stop_ev & (st_q == ST_WDATA) & scl_fall & (bit_q == 4'd8);
  assign pb_clr = tmr_done | (start_ev & ~busy);

  seep_page_buf #(.PAGE_W(PAGE_W)) u_pbuf (
    .clk_i, .rst_ni,
    .we_i(pb_we), .widx_i(waddr_q[PAGE_W-1:0]), .wdata_i(sh_q),
    .clr_i(pb_clr), .ridx_i(tmr_idx), .rdata_o(mem_wdata_o), .valid_o(pb_valid)
  );

  // bit 7 compares inverted, bit 6 compares true
  assign hdr_match = (sh_q[7] == ~dev_sel_i[1]) && (sh_q[6] == dev_sel_i[0]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      bit_q    <= '0;
      sh_q     <= '0;
      tx_q     <= '0;
      sda_lo_q <= 1'b0;
      rd_q     <= 1'b0;
      hi_q     <= '0;
      ptr_q    <= '0;
      waddr_q  <= '0;
    end else if (busy) begin
      st_q     <= ST_IDLE;
      bit_q    <= '0;
      sda_lo_q <= 1'b0;
    end else if (start_ev) begin
      st_q     <= ST_DEV;
      bit_q    <= '0;
      sda_lo_q <= 1'b0;
    end else if (stop_ev) begin
      st_q     <= ST_IDLE;
      bit_q    <= '0;
      sda_lo_q <= 1'b0;
    end else begin
      case (st_q)
        ST_DEV, ST_WORD, ST_WDATA: begin
          if (scl_rise) begin
            if (bit_q < 4'd8) begin
              sh_q  <= {sh_q[6:0], sda_s};
              bit_q <= bit_q + 1'b1;
            end else if (bit_q == 4'd8) begin
              bit_q <= 4'd9;
            end
          end else if (scl_fall) begin
            if (bit_q == 4'd8) begin
              case (st_q)
                ST_DEV: begin
                  if (hdr_match) begin
                    sda_lo_q <= 1'b1;
                    hi_q     <= sh_q[HI_W:1];
                    rd_q     <= sh_q[0];
                  end else begin
                    st_q  <= ST_IDLE;
                    bit_q <= '0;
                  end
                end
                ST_WORD: begin
                  sda_lo_q <= 1'b1;
                  ptr_q    <= {hi_q, sh_q};
                  waddr_q  <= {hi_q, sh_q};
                end
                default: begin
                  sda_lo_q <= 1'b1;
                  ptr_q    <= waddr_q;
                  waddr_q  <= {waddr_q[ADDR_W-1:PAGE_W], waddr_q[PAGE_W-1:0] + PAGE_W'(1)};
                end
              endcase
            end else if (bit_q == 4'd9) begin
              sda_lo_q <= 1'b0;
              bit_q    <= '0;
              if (st_q == ST_DEV) begin
                if (rd_q) begin
                  st_q     <= ST_RDATA;
                  tx_q     <= mem_rdata_i;
                  sda_lo_q <= ~mem_rdata_i[7];
                  ptr_q    <= ptr_q + 1'b1;
                end else begin
                  st_q <= ST_WORD;
                end
              end else if (st_q == ST_WORD) begin
                st_q <= ST_WDATA;
              end
            end
          end
        end
        ST_RDATA: begin
          if (scl_rise) begin
            if (bit_q < 4'd8) begin
              bit_q <= bit_q + 1'b1;
            end else if (bit_q == 4'd8) begin
              if (!sda_s) begin
                bit_q <= 4'd9;
              end else begin
                st_q  <= ST_IDLE;
                bit_q <= '0;
              end
            end
          end else if (scl_fall) begin
            if (bit_q == 4'd9) begin
              tx_q     <= mem_rdata_i;
              sda_lo_q <= ~mem_rdata_i[7];
              ptr_q    <= ptr_q + 1'b1;
              bit_q    <= '0;
            end else if (bit_q == 4'd8) begin
              sda_lo_q <= 1'b0;
            end else if (bit_q != 4'd0) begin
              tx_q     <= {tx_q[6:0], 1'b0};
              sda_lo_q <= ~tx_q[6];
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign sda_lo_o   = sda_lo_q;
  assign mem_we_o   = tmr_commit & pb_valid[tmr_idx];
  assign mem_addr_o = busy ? {waddr_q[ADDR_W-1:PAGE_W], tmr_idx} : ptr_q;
endmodule

// File: rtl/seep_checker.sv
module seep_checker #(
  parameter int unsigned ADDR_W = 13,
  parameter int unsigned PAGE_W = 5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              scl_i,
  input logic              sda_lo_i,
  input logic              mem_we_i,
  input logic [ADDR_W-1:0] mem_addr_i,
  input logic              busy_i
);
  assert_reset_release_R1: assert property (@(posedge clk_i)
    !rst_ni |=> (!sda_lo_i && !mem_we_i));

  assert_sda_scl_low_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sda_lo_i != $past(sda_lo_i)) |-> !scl_i);

  assert_deaf_busy_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |-> !sda_lo_i);

  assert_write_in_busy_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_i |-> busy_i);

  assert_page_fixed_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_i && $past(mem_we_i)) |->
      (mem_addr_i[ADDR_W-1:PAGE_W] == $past(mem_addr_i[ADDR_W-1:PAGE_W])));
endmodule

bind serial_eeprom_slave seep_checker #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .scl_i(scl_i), .sda_lo_i(sda_lo_o),
  .mem_we_i(mem_we_o), .mem_addr_i(mem_addr_o), .busy_i(busy)
);

// File: tb/serial_eeprom_slave_tb.sv
`timescale 1ns/1ps
module serial_eeprom_slave_tb;
  localparam int WR = 256;
  localparam int Q  = 8;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_lo, sda_line, mem_we;
  logic [12:0] mem_addr;
  logic [7:0] mem_wdata, mem_rdata;
  logic [1:0] dev_sel = 2'b01;

  always #2 clk = ~clk;
  assign sda_line = sda_m & ~sda_lo;

  serial_eeprom_slave #(.WR_CYCLES(WR)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .scl_i(scl_m), .sda_i(sda_line),
    .sda_lo_o(sda_lo), .dev_sel_i(dev_sel), .mem_addr_o(mem_addr),
    .mem_we_o(mem_we), .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata)
  );

  logic [7:0] mem_m [int];
  int we_cnt = 0;
  always @(posedge clk) begin
    if (mem_we) begin
      mem_m[int'(mem_addr)] = mem_wdata;
      we_cnt++;
    end
    mem_rdata <= mem_m.exists(int'(mem_addr)) ? mem_m[int'(mem_addr)] : 8'hFF;
  end

  int n_tests = 0, n_fail = 0;
  task automatic chk(string tag, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  typedef struct { int val; string tag; } item_t;
  item_t exp_q[$];
  event obs_ev;
  int obs_val;

  task automatic expect_item(int v, string tag);
    item_t it;
    it.val = v; it.tag = tag;
    exp_q.push_back(it);
  endtask

  task automatic observe(int v);
    obs_val = v;
    -> obs_ev;
  endtask

  initial begin
    forever begin
      @(obs_ev);
      if (exp_q.size() == 0) chk("scoreboard underflow", 1, 0);
      else begin
        item_t it;
        it = exp_q.pop_front();
        chk(it.tag, obs_val, it.val);
      end
    end
  end

  // reference model
  logic [7:0] ref_mem [int];
  int ref_ptr = 0;
  function automatic logic [7:0] rget(int a);
    return ref_mem.exists(a) ? ref_mem[a] : 8'hFF;
  endfunction
  function automatic logic [7:0] hdr(int a, bit rd);
    logic [12:0] aa;
    aa = 13'(a);
    return {2'b11, aa[12:8], rd};
  endfunction

  task automatic q();
    repeat (Q) @(negedge clk);
  endtask
  task automatic bus_start();
    sda_m = 1'b1; q(); scl_m = 1'b1; q(); sda_m = 1'b0; q(); scl_m = 1'b0; q();
  endtask
  task automatic bus_stop();
    sda_m = 1'b0; q(); scl_m = 1'b1; q(); sda_m = 1'b1; q();
  endtask
  task automatic put_bit(bit b);
    sda_m = b; q(); scl_m = 1'b1; q(); q(); scl_m = 1'b0; q();
  endtask
  task automatic get_bit(output bit b);
    sda_m = 1'b1; q(); scl_m = 1'b1; q(); b = sda_line; q(); scl_m = 1'b0; q();
  endtask
  task automatic send_byte(logic [7:0] v, bit ack_exp, string tag);
    bit a;
    for (int i = 7; i >= 0; i--) put_bit(v[i]);
    get_bit(a);
    expect_item(ack_exp ? 0 : 1, tag);
    observe(int'(a));
  endtask
  task automatic recv_byte(logic [7:0] exp, bit mack, string tag);
    logic [7:0] v;
    bit b;
    for (int i = 7; i >= 0; i--) begin get_bit(b); v[i] = b; end
    put_bit(!mack);
    sda_m = 1'b1;
    expect_item(int'(exp), tag);
    observe(int'(v));
  endtask

  task automatic write_seq(int addr, logic [7:0] d[$], string tag);
    int a = addr;
    bus_start();
    send_byte(hdr(addr, 0), 1, {tag, " hdr ack"});
    send_byte(8'(addr), 1, {tag, " addr ack"});
    foreach (d[k]) begin
      send_byte(d[k], 1, {tag, " data ack"});
      ref_mem[a] = d[k];
      ref_ptr = a;
      a = (a & 13'h1FE0) | ((a + 1) & 31);
    end
    bus_stop();
  endtask
  task automatic wait_wr();
    repeat (WR + 40) @(negedge clk);
  endtask
  task automatic read_random(int addr, int n, string tag);
    bus_start();
    send_byte(hdr(addr, 0), 1, {tag, " hdr ack"});
    send_byte(8'(addr), 1, {tag, " addr ack"});
    bus_start();
    send_byte(hdr(0, 1), 1, {tag, " rd hdr ack"});
    ref_ptr = addr;
    for (int k = 0; k < n; k++) begin
      recv_byte(rget(ref_ptr), k < n - 1, {tag, " data"});
      ref_ptr = (ref_ptr + 1) & 8191;
    end
    bus_stop();
  endtask
  task automatic read_current(int n, string tag);
    bus_start();
    send_byte(hdr(0, 1), 1, {tag, " rd hdr ack"});
    for (int k = 0; k < n; k++) begin
      recv_byte(rget(ref_ptr), k < n - 1, {tag, " data"});
      ref_ptr = (ref_ptr + 1) & 8191;
    end
    bus_stop();
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [7:0] d[$];
    repeat (5) @(negedge clk);
    chk("R1 sda released in reset", int'(sda_lo), 0);
    rst_ni = 1'b1;
    repeat (5) @(negedge clk);
    chk("R1 sda released after reset", int'(sda_lo), 0);
    chk("R1 no mem write after reset", int'(mem_we), 0);

    // R3 byte write, R5 busy polling
    d = '{8'hA5};
    write_seq(13'h0123, d, "R3");
    bus_start();
    send_byte(hdr(0, 0), 0, "R5 no ack while busy");
    bus_stop();
    wait_wr();
    chk("R11 one write per byte", we_cnt, 1);
    bus_start();
    send_byte(hdr(0, 0), 1, "R5 ack after busy");
    bus_stop();
    // R6 header-only write starts no busy; R8 last written address
    read_current(1, "R8 last written R6");
    read_current(1, "R8 last read plus one");

    // R2 select compare and deafness after mismatch
    bus_start();
    send_byte(8'b0100_0000, 0, "R2 bit7 not inverted");
    send_byte(hdr(0, 0), 0, "R2 ignored until start");
    bus_stop();
    bus_start();
    send_byte(8'b1000_0000, 0, "R2 bit6 mismatch");
    bus_stop();

    // R4 page wrap within page, R10 random read
    we_cnt = 0;
    d = '{8'h11, 8'h22, 8'h33, 8'h44, 8'h55, 8'h66};
    write_seq(13'h0A1C, d, "R4 wrap");
    wait_wr();
    chk("R11 six writes", we_cnt, 6);
    read_random(13'h0A1C, 4, "R10 R4 page top");
    read_random(13'h0A00, 2, "R4 wrapped bytes");

    // R4 overflow past 32 bytes
    we_cnt = 0;
    d = {};
    for (int k = 0; k < 34; k++) d.push_back(8'(k * 7 + 3));
    write_seq(13'h0040, d, "R4 overflow");
    wait_wr();
    chk("R11 distinct bytes only", we_cnt, 32);
    read_random(13'h0040, 32, "R4 overflow readback");

    // R9 read wrap 8191 -> 0
    d = '{8'h3C};
    write_seq(13'h1FFF, d, "R9 top");
    wait_wr();
    d = '{8'h7E};
    write_seq(13'h0000, d, "R9 bottom");
    wait_wr();
    read_random(13'h1FFF, 2, "R9 wrap");

    // R6 stop mid-byte
    we_cnt = 0;
    bus_start();
    send_byte(hdr(13'h0200, 0), 1, "R6 hdr");
    send_byte(8'h00, 1, "R6 addr");
    put_bit(1'b0); put_bit(1'b1); put_bit(1'b0); put_bit(1'b1);
    bus_stop();
    read_random(13'h0200, 1, "R6 partial discarded");
    chk("R6 no memory write", we_cnt, 0);

    // R7 master NACK ends transmission
    d = '{8'h00};
    write_seq(13'h0300, d, "R7 setup");
    wait_wr();
    bus_start();
    send_byte(hdr(13'h0300, 0), 1, "R7 hdr");
    send_byte(8'h00, 1, "R7 addr");
    bus_start();
    send_byte(hdr(0, 1), 1, "R7 rd hdr");
    recv_byte(8'h00, 0, "R7 data before nack");
    recv_byte(8'hFF, 0, "R7 released after nack");
    bus_stop();

    repeat (20) @(negedge clk);
    chk("scoreboard drained", exp_q.size(), 0);
    finish_run();
  end
endmodule